// File: doc/BRIEF.md
# Multi-Level Translation Table Walker

This block turns a 64-bit virtual address into a real page address by following a chain of translation tables held in memory. A request carries the address, a read/write flag and a 2-bit address-space mode. The mode picks one of three table designators, which the block takes from three control-register inputs. A 2-bit type field in that designator names the table level where the walk starts. From there the block fetches one 8-byte entry per level through a simple read port. Each fetched entry then serves as the designator for the next level down, until the page entry is reached.

A walk ends in one of two ways. The first is a one-cycle `done_o` pulse, carrying the real page address and a writable flag. The second is a one-cycle `fault_o` pulse, carrying a fault class and an exception word. When translation is switched off, the page-aligned virtual address is returned unchanged and no memory is read. In every successful result, an address below 0x2000 is moved into the window given by the prefix input. The block serves one walk at a time and takes a new request only when idle.

Top module: `xlat_walker`

## Requirements
- R1: The designator comes from `cr1_i` when the mode is 0 (primary), from `cr7_i` when the mode is 1 (secondary) and from `cr13_i` when the mode is 2 (home). Mode 3 is reserved and ends at once in a specification fault.
- R2: Designator bits [3:2] give the starting table. The value 3 starts at the region-first table, 2 at the region-second table, 1 at the region-third table and 0 at the segment table. The address must fit the starting level, otherwise a specification fault is raised and no memory is read. For a start at the region-second table, address bits [63:53] must be zero. For the region-third table, bits [63:42] must be zero. For the segment table, bits [63:31] must be zero.
- R3: Each entry address is the current table origin plus the index times 8. The index is bits [63:53] in the region-first table, [52:42] in the region-second table, [41:31] in the region-third table, [30:20] in the segment table and [19:12] in the page table. The origin is bits [63:12] of the designator or region entry, and bits [63:11] of a segment-table entry.
- R4: In a region or segment-table entry, bit 5 set raises a segment-translation fault. If bit 5 is clear and bits [3:2] differ from the level below that table (region-first 3, region-second 2, region-third 1, segment 0), a specification fault is raised.
- R5: In a page entry, bit 10 set raises a page-translation fault. Otherwise the real address is the entry with bits [11:0] cleared, and `writable_o` is the inverse of bit 9.
- R6: A write to a page entry with bit 9 set raises a protection fault, and its exception word also has bit 2 set. A page entry with bit 10 set gives a page-translation fault even when the protection condition also holds.
- R7: Fault codes on `fault_code_o` are 1 for segment-translation, 2 for page-translation, 3 for specification and 4 for protection. The exception word is the virtual address with bits [11:0] cleared, ORed with mode bits: 0 for primary, 2 for secondary, 3 for home and 1 for the reserved mode.
- R8: With `xlate_en_i` low, the result is the virtual address with bits [11:0] cleared, `writable_o` is 1, no memory read is made, and `done_o` pulses in the cycle after acceptance.
- R9: A successful result below 0x2000 has `prefix_i` added to it. A result at or above 0x2000 is returned unchanged.
- R10: `ready_o` is high only when idle, and a request presented while busy is ignored. `done_o` and `fault_o` are each high for exactly one cycle per accepted request, and never together. After reset `ready_o` is 1 and `done_o`, `fault_o` and `mem_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request, accepted when `ready_o` is high |
| req_vaddr_i | input | 64 | Virtual address to translate |
| req_write_i | input | 1 | Request is a write |
| req_mode_i | input | 2 | Address-space mode: 0 primary, 1 secondary, 2 home, 3 reserved |
| xlate_en_i | input | 1 | Translation enabled |
| cr1_i | input | 64 | Primary designator |
| cr7_i | input | 64 | Secondary designator |
| cr13_i | input | 64 | Home designator |
| prefix_i | input | 64 | Offset added to real addresses below 0x2000 |
| ready_o | output | 1 | Idle, able to accept a request |
| mem_req_o | output | 1 | One-cycle read request for an 8-byte entry |
| mem_addr_o | output | 64 | Entry address, valid with `mem_req_o` |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Entry read from memory |
| done_o | output | 1 | Successful translation, one cycle |
| paddr_o | output | 64 | Real page address, valid with `done_o` |
| writable_o | output | 1 | Page may be written, valid with `done_o` |
| fault_o | output | 1 | Translation fault, one cycle |
| fault_code_o | output | 3 | Fault class, valid with `fault_o` |
| exc_word_o | output | 64 | Exception word, valid with `fault_o` |

## Verification
The final page entry is checked in a single cycle, and two checks act on it there: the invalid-page check and the write-protection check. The bench builds page entries with both bit 10 and bit 9 set and sends write requests to them. It expects a page-translation fault, with bit 2 of the exception word clear. The same entry with only bit 9 set, under a write, must give the protection fault, and under a read it must give a success with `writable_o` low. The random run mixes these flag combinations at random, and a reference walk in the bench judges every outcome.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int TYPE_LSB    = 2;
  localparam int TYPE_W      = 2;
  localparam int ENT_INV_BIT = 5;
  localparam int PG_INV_BIT  = 10;
  localparam int PG_RO_BIT   = 9;
  localparam int SEG_ORG_LSB = 11;
  localparam int ENT_LG      = 3;
  localparam int PROT_FLAG   = 4;

  localparam logic [1:0] MODE_PRI  = 2'd0;
  localparam logic [1:0] MODE_SEC  = 2'd1;
  localparam logic [1:0] MODE_HOME = 2'd2;
  localparam logic [1:0] MODE_RSV  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_CHECK, ST_DONE, ST_FAULT
  } state_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_SEG  = 3'd1,
    FLT_PAGE = 3'd2,
    FLT_SPEC = 3'd3,
    FLT_PROT = 3'd4
  } fault_e;
endpackage

// File: rtl/xw_desig_sel.sv
module xw_desig_sel
  import xw_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 11,
  parameter int PT_IDX_W = 8,
  parameter int N_RGN    = 4,
  parameter int LVL_W    = 3
) (
  input  logic [1:0]      mode_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  logic [VA_W-1:0] cr1_i,
  input  logic [VA_W-1:0] cr7_i,
  input  logic [VA_W-1:0] cr13_i,
  output logic [VA_W-1:0] desig_o,
  output logic [LVL_W-1:0] start_lvl_o,
  output logic            mode_bad_o,
  output logic            fits_o,
  output logic [1:0]      mode_bits_o
);
  logic [N_RGN:0] fit_v;

  always_comb begin
    desig_o     = cr1_i;
    mode_bad_o  = 1'b0;
    mode_bits_o = 2'd0;
    unique case (mode_i)
      MODE_PRI:  begin desig_o = cr1_i;  mode_bits_o = 2'd0; end
      MODE_SEC:  begin desig_o = cr7_i;  mode_bits_o = 2'd2; end
      MODE_HOME: begin desig_o = cr13_i; mode_bits_o = 2'd3; end
      default:   begin mode_bad_o = 1'b1; mode_bits_o = 2'd1; end
    endcase
  end

  assign start_lvl_o = LVL_W'(desig_o[TYPE_LSB +: TYPE_W]) + LVL_W'(1);

  // table level k holds index bits starting at FLSB; top level always fits
  assign fit_v[0] = 1'b0;
  for (genvar k = 1; k <= N_RGN; k++) begin : g_fit
    localparam int FLSB = PG_SHIFT + PT_IDX_W + IDX_W * (k - 1);
    if (k == N_RGN) begin : g_top
      assign fit_v[k] = 1'b1;
    end else begin : g_low
      assign fit_v[k] = ((vaddr_i >> (FLSB + IDX_W)) == '0);
    end
  end

  assign fits_o = fit_v[start_lvl_o];
endmodule

// File: rtl/xw_index_gen.sv
module xw_index_gen
  import xw_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 11,
  parameter int PT_IDX_W = 8,
  parameter int N_RGN    = 4,
  parameter int LVL_W    = 3
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [VA_W-1:0]  offset_o
);
  logic [VA_W-1:0] off_v [N_RGN+1];

  for (genvar k = 0; k <= N_RGN; k++) begin : g_off
    if (k == 0) begin : g_pt
      assign off_v[k] = ((vaddr_i >> PG_SHIFT) & VA_W'({PT_IDX_W{1'b1}})) << ENT_LG;
    end else begin : g_rt
      localparam int FLSB = PG_SHIFT + PT_IDX_W + IDX_W * (k - 1);
      assign off_v[k] = ((vaddr_i >> FLSB) & VA_W'({IDX_W{1'b1}})) << ENT_LG;
    end
  end

  assign offset_o = (lvl_i <= LVL_W'(N_RGN)) ? off_v[lvl_i] : '0;
endmodule

// File: rtl/xw_entry_chk.sv
module xw_entry_chk
  import xw_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PG_SHIFT = 12,
  parameter int LVL_W    = 3
) (
  input  logic [VA_W-1:0]  entry_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             write_i,
  output fault_e           code_o,
  output logic [VA_W-1:0]  next_origin_o,
  output logic [VA_W-1:0]  real_o,
  output logic             writable_o
);
  localparam logic [VA_W-1:0] PG_OFS  = VA_W'({PG_SHIFT{1'b1}});
  localparam logic [VA_W-1:0] SEG_OFS = VA_W'({SEG_ORG_LSB{1'b1}});

  logic ro;
  assign ro            = entry_i[PG_RO_BIT];
  assign real_o        = entry_i & ~PG_OFS;
  assign writable_o    = ~ro;
  assign next_origin_o = (lvl_i == LVL_W'(1)) ? (entry_i & ~SEG_OFS) : (entry_i & ~PG_OFS);

  always_comb begin
    code_o = FLT_NONE;
    if (lvl_i != '0) begin
      if (entry_i[ENT_INV_BIT])
        code_o = FLT_SEG;
      else if (entry_i[TYPE_LSB +: TYPE_W] != TYPE_W'(lvl_i - LVL_W'(1)))
        code_o = FLT_SPEC;
    end else begin
      // invalid page wins over protection
      if (entry_i[PG_INV_BIT])
        code_o = FLT_PAGE;
      else if (write_i && ro)
        code_o = FLT_PROT;
    end
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 11,
  parameter int PT_IDX_W = 8,
  parameter int N_RGN    = 4,
  parameter logic [VA_W-1:0] LOW_WIN = 'h2000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic            req_write_i,
  input  logic [1:0]      req_mode_i,
  input  logic            xlate_en_i,
  input  logic [VA_W-1:0] cr1_i,
  input  logic [VA_W-1:0] cr7_i,
  input  logic [VA_W-1:0] cr13_i,
  input  logic [VA_W-1:0] prefix_i,
  output logic            ready_o,
  output logic            mem_req_o,
  output logic [VA_W-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [VA_W-1:0] mem_rdata_i,
  output logic            done_o,
  output logic [VA_W-1:0] paddr_o,
  output logic            writable_o,
  output logic            fault_o,
  output logic [2:0]      fault_code_o,
  output logic [VA_W-1:0] exc_word_o
);
  localparam int LVL_W = $clog2(N_RGN + 1);
  localparam logic [VA_W-1:0] PG_OFS = VA_W'({PG_SHIFT{1'b1}});

  state_e          state_q;
  logic [VA_W-1:0] vaddr_q, origin_q, entry_q, paddr_q, exc_q;
  logic [LVL_W-1:0] lvl_q;
  logic            write_q, writable_q;
  logic [1:0]      mbits_q;
  fault_e          fcode_q;

  logic [VA_W-1:0]  desig, offset, next_origin, real_pg, req_pg;
  logic [LVL_W-1:0] start_lvl;
  logic             mode_bad, fits, ent_wr;
  logic [1:0]       mode_bits;
  fault_e           ent_code;

  function automatic logic [VA_W-1:0] add_prefix(input logic [VA_W-1:0] a,
                                                  input logic [VA_W-1:0] p);
    return (a < LOW_WIN) ? a + p : a;
  endfunction

  assign req_pg = req_vaddr_i & ~PG_OFS;

  xw_desig_sel #(
    .VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
    .PT_IDX_W(PT_IDX_W), .N_RGN(N_RGN), .LVL_W(LVL_W)
  ) u_sel (
    .mode_i(req_mode_i), .vaddr_i(req_pg),
    .cr1_i(cr1_i), .cr7_i(cr7_i), .cr13_i(cr13_i),
    .desig_o(desig), .start_lvl_o(start_lvl), .mode_bad_o(mode_bad),
    .fits_o(fits), .mode_bits_o(mode_bits)
  );

  xw_index_gen #(
    .VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
    .PT_IDX_W(PT_IDX_W), .N_RGN(N_RGN), .LVL_W(LVL_W)
  ) u_idx (
    .vaddr_i(vaddr_q), .lvl_i(lvl_q), .offset_o(offset)
  );

  xw_entry_chk #(
    .VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .LVL_W(LVL_W)
  ) u_chk (
    .entry_i(entry_q), .lvl_i(lvl_q), .write_i(write_q),
    .code_o(ent_code), .next_origin_o(next_origin),
    .real_o(real_pg), .writable_o(ent_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      vaddr_q    <= '0;
      origin_q   <= '0;
      entry_q    <= '0;
      paddr_q    <= '0;
      exc_q      <= '0;
      lvl_q      <= '0;
      write_q    <= 1'b0;
      writable_q <= 1'b0;
      mbits_q    <= '0;
      fcode_q    <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q <= req_pg;
          write_q <= req_write_i;
          mbits_q <= mode_bits;
          if (!xlate_en_i) begin
            paddr_q    <= add_prefix(req_pg, prefix_i);
            writable_q <= 1'b1;
            state_q    <= ST_DONE;
          end else if (mode_bad || !fits) begin
            fcode_q <= FLT_SPEC;
            exc_q   <= req_pg | VA_W'(mode_bits);
            state_q <= ST_FAULT;
          end else begin
            origin_q <= desig & ~PG_OFS;
            lvl_q    <= start_lvl;
            state_q  <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          entry_q <= mem_rdata_i;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (ent_code != FLT_NONE) begin
            fcode_q <= ent_code;
            exc_q   <= vaddr_q | VA_W'(mbits_q)
                     | ((ent_code == FLT_PROT) ? VA_W'(PROT_FLAG) : '0);
            state_q <= ST_FAULT;
          end else if (lvl_q == '0) begin
            paddr_q    <= add_prefix(real_pg, prefix_i);
            writable_q <= ent_wr;
            state_q    <= ST_DONE;
          end else begin
            origin_q <= next_origin;
            lvl_q    <= lvl_q - LVL_W'(1);
            state_q  <= ST_FETCH;
          end
        end
        ST_DONE:  state_q <= ST_IDLE;
        ST_FAULT: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o      = (state_q == ST_IDLE);
  assign mem_req_o    = (state_q == ST_FETCH);
  assign mem_addr_o   = origin_q + offset;
  assign done_o       = (state_q == ST_DONE);
  assign fault_o      = (state_q == ST_FAULT);
  assign paddr_o      = paddr_q;
  assign writable_o   = writable_q;
  assign fault_code_o = fcode_q;
  assign exc_word_o   = exc_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  fault_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);
  // R10
  done_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
  // R10
  busy_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);
  // R3
  fetch_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[ENT_LG-1:0] == '0));
  // R8
  off_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_valid_i && !xlate_en_i) |=> (done_o && writable_o));
  // R2
  range_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_valid_i && xlate_en_i && !mode_bad && !fits)
      |=> (fault_o && fault_code_o == FLT_SPEC));
  // R6
  prot_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && fault_code_o == FLT_PROT) |-> (write_q && exc_word_o[2]));
endmodule

// File: tb/tb_xlat_walker.sv
`timescale 1ns/1ps
module tb_xlat_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, xlate_en = 1'b0;
  logic [63:0] req_vaddr = '0, cr1 = '0, cr7 = '0, cr13 = '0, prefix = '0;
  logic [1:0]  req_mode = '0;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        ready, mem_req, done, wr_ok, fault;
  logic [63:0] mem_addr, paddr, exc_word;
  logic [2:0]  fcode;

  int checks = 0, failures = 0, reads = 0;
  logic [63:0] mem [logic [63:0]];

  always #4 clk = ~clk;

  xlat_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_mode_i(req_mode), .xlate_en_i(xlate_en),
    .cr1_i(cr1), .cr7_i(cr7), .cr13_i(cr13), .prefix_i(prefix),
    .ready_o(ready), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .done_o(done),
    .paddr_o(paddr), .writable_o(wr_ok), .fault_o(fault),
    .fault_code_o(fcode), .exc_word_o(exc_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] boff(input int k, input logic [63:0] va);
    if (k == 0) return ((va >> 12) & 64'hFF) << 3;
    return ((va >> (20 + 11 * (k - 1))) & 64'h7FF) << 3;
  endfunction

  function automatic logic [63:0] mbits(input logic [1:0] m);
    case (m)
      2'd0: return 64'd0;
      2'd1: return 64'd2;
      2'd2: return 64'd3;
      default: return 64'd1;
    endcase
  endfunction

  function automatic logic [63:0] pfx(input logic [63:0] a);
    return (a < 64'h2000) ? a + prefix : a;
  endfunction

  function automatic logic [63:0] rnd_page();
    return {24'd0, 28'($urandom), 12'd0};
  endfunction

  // reference walk from the requirements
  task automatic ref_walk(input logic [63:0] va, input bit wr, input logic [1:0] mode,
                          input bit xen, output bit e_done, output logic [2:0] e_code,
                          output logic [63:0] e_exc, output logic [63:0] e_pa,
                          output bit e_wr, output int e_reads);
    logic [63:0] pg, d, org, e;
    int t;
    pg = va & ~64'hFFF;
    e_done = 1'b0; e_code = 3'd0; e_exc = '0; e_pa = '0; e_wr = 1'b0; e_reads = 0;
    if (!xen) begin e_done = 1'b1; e_pa = pfx(pg); e_wr = 1'b1; return; end
    if (mode == 2'd3) begin e_code = 3'd3; e_exc = pg | 64'd1; return; end
    d = (mode == 2'd0) ? cr1 : (mode == 2'd1) ? cr7 : cr13;
    t = int'(d[3:2]);
    if ((t == 2 && pg[63:53] != 0) || (t == 1 && pg[63:42] != 0) ||
        (t == 0 && pg[63:31] != 0)) begin
      e_code = 3'd3; e_exc = pg | mbits(mode); return;
    end
    org = d & ~64'hFFF;
    for (int k = t + 1; k >= 0; k--) begin
      e_reads++;
      e = rd(org + boff(k, pg));
      if (k > 0) begin
        if (e[5]) begin e_code = 3'd1; e_exc = pg | mbits(mode); return; end
        if (int'(e[3:2]) != k - 1) begin e_code = 3'd3; e_exc = pg | mbits(mode); return; end
        org = (k == 1) ? (e & ~64'h7FF) : (e & ~64'hFFF);
      end else begin
        if (e[10]) begin e_code = 3'd2; e_exc = pg | mbits(mode); return; end
        if (wr && e[9]) begin e_code = 3'd4; e_exc = pg | mbits(mode) | 64'd4; return; end
        e_done = 1'b1; e_pa = pfx(e & ~64'hFFF); e_wr = !e[9];
      end
    end
  endtask

  // bad_kind: 1 invalid bit, 2 wrong type (bad_lvl > 0 only)
  task automatic build(input logic [63:0] va, input logic [1:0] typ, input int bad_lvl,
                       input int bad_kind, input bit ro, input logic [63:0] real_pg,
                       output logic [63:0] desig);
    logic [63:0] org, nxt, e;
    mem.delete();
    org = rnd_page();
    desig = org | (64'(typ) << 2);
    for (int k = int'(typ) + 1; k >= 0; k--) begin
      if (k == 0) begin
        e = real_pg & ~64'hFFF;
        if (ro) e[9] = 1'b1;
        if (bad_lvl == 0 && bad_kind == 1) e[10] = 1'b1;
      end else begin
        nxt = (k == 1) ? {24'd0, 29'($urandom), 11'd0} : rnd_page();
        e = nxt;
        e[3:2] = 2'(k - 1);
        if (bad_lvl == k && bad_kind == 1) e[5] = 1'b1;
        if (bad_lvl == k && bad_kind == 2) e[3:2] = 2'(k - 1) ^ 2'd1;
      end
      mem[org + boff(k, va)] = e;
      org = nxt;
    end
  endtask

  task automatic set_crs(input logic [1:0] mode, input logic [63:0] d);
    cr1 = {$urandom, $urandom}; cr7 = {$urandom, $urandom}; cr13 = {$urandom, $urandom};
    case (mode)
      2'd0: cr1 = d;
      2'd1: cr7 = d;
      2'd2: cr13 = d;
      default: ;
    endcase
  endtask

  task automatic run_one(input string req, input logic [63:0] va, input bit wr,
                         input logic [1:0] mode, input bit xen);
    bit e_done, e_wr;
    logic [2:0] e_code;
    logic [63:0] e_exc, e_pa;
    int e_reads, n;
    ref_walk(va, wr, mode, xen, e_done, e_code, e_exc, e_pa, e_wr, e_reads);
    @(negedge clk);
    reads = 0;
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_mode = mode; xlate_en = xen;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!(done || fault) && n < 400) begin @(negedge clk); n++; end
    if (n >= 400) begin
      chk(1'b0, req, "timeout", 64'(n), 64'd0);
      return;
    end
    chk(done == e_done && fault == !e_done, req, "outcome", {62'd0, done, fault},
        {62'd0, e_done, !e_done});
    if (e_done) begin
      chk(paddr == e_pa, req, "paddr", paddr, e_pa);
      chk(wr_ok == e_wr, req, "writable", 64'(wr_ok), 64'(e_wr));
    end else begin
      chk(fcode == e_code, req, "fault_code", 64'(fcode), 64'(e_code));
      chk(exc_word == e_exc, req, "exc_word", exc_word, e_exc);
    end
    chk(reads == e_reads, req, "reads", 64'(reads), 64'(e_reads));
    @(negedge clk);
    chk(!done && !fault, "R10", "pulse width", {62'd0, done, fault}, 64'd0);
  endtask

  task automatic drun(input string req, input logic [63:0] va, input bit wr,
                      input logic [1:0] mode, input logic [1:0] typ, input int bad_lvl,
                      input int bad_kind, input bit ro, input logic [63:0] real_pg);
    logic [63:0] d;
    build(va, typ, bad_lvl, bad_kind, ro, real_pg, d);
    set_crs(mode, d);
    run_one(req, va, wr, mode, 1'b1);
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [63:0] a;
        a = mem_addr;
        reads++;
        repeat (1 + ($urandom % 3)) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = rd(a);
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = {$urandom, $urandom};
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] d, va;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ready && !done && !fault && !mem_req, "R10", "reset state",
        {60'd0, ready, done, fault, mem_req}, 64'h8);
    rst_n = 1'b1;
    prefix = 64'h0007_0000;

    // R8 identity, R9 prefix window and its boundary
    run_one("R8", 64'h0000_1234_5678_9ABC, 1'b1, 2'd0, 1'b0);
    run_one("R9", 64'h0000_0000_0000_1FFF, 1'b0, 2'd1, 1'b0);
    run_one("R9", 64'h0000_0000_0000_2000, 1'b0, 2'd1, 1'b0);

    // R3 full walks from each starting table, R1 selection by mode
    drun("R3", 64'hABCD_1234_5678_9000, 1'b0, 2'd0, 2'd3, -1, 0, 1'b0, 64'h0000_0055_AAAA_B000);
    drun("R3", 64'h001F_FFFF_FFFF_F000, 1'b1, 2'd1, 2'd2, -1, 0, 1'b0, 64'h0000_0000_1234_5000);
    drun("R1", 64'h0000_03FF_F00F_F000, 1'b0, 2'd2, 2'd1, -1, 0, 1'b0, 64'h0000_0000_0777_7000);
    drun("R1", 64'h0000_0000_7FFF_F000, 1'b1, 2'd0, 2'd0, -1, 0, 1'b0, 64'h0000_0000_9999_9000);
    // R1 reserved mode
    drun("R1", 64'h0000_0000_0012_3000, 1'b0, 2'd3, 2'd0, -1, 0, 1'b0, 64'h0000_0000_0004_0000);
    // R2 range faults for each limited start
    drun("R2", 64'h0020_0000_0000_0000, 1'b0, 2'd0, 2'd2, -1, 0, 1'b0, 64'h3000);
    drun("R2", 64'h0000_0400_0000_0000, 1'b0, 2'd1, 2'd1, -1, 0, 1'b0, 64'h3000);
    drun("R2", 64'h0000_0000_8000_0000, 1'b0, 2'd2, 2'd0, -1, 0, 1'b0, 64'h3000);
    // R4 invalid region entry, wrong type, invalid segment entry
    drun("R4", 64'h1234_0000_0000_0000, 1'b0, 2'd1, 2'd3, 3, 1, 1'b0, 64'h5000);
    drun("R4", 64'h1234_0000_0000_0000, 1'b0, 2'd2, 2'd3, 2, 2, 1'b0, 64'h5000);
    drun("R4", 64'h0000_0000_1234_5000, 1'b0, 2'd0, 2'd0, 1, 1, 1'b0, 64'h5000);
    // R5 page invalid, read-only read
    drun("R5", 64'h0000_0000_1234_5000, 1'b0, 2'd0, 2'd0, 0, 1, 1'b0, 64'h5000);
    drun("R5", 64'h0000_0000_1234_5000, 1'b0, 2'd0, 2'd0, -1, 0, 1'b1, 64'h0000_0000_ABCD_E000);
    // R6/R7 protection in home mode, invalid wins over protection
    drun("R6", 64'h0000_0000_1234_5000, 1'b1, 2'd2, 2'd0, -1, 0, 1'b1, 64'h6000);
    drun("R6", 64'h0000_0000_1234_5000, 1'b1, 2'd1, 2'd0, 0, 1, 1'b1, 64'h6000);
    drun("R7", 64'h0000_0000_0ABC_D000, 1'b0, 2'd1, 2'd0, 1, 2, 1'b0, 64'h6000);
    // R9 through a walk: real page below window
    drun("R9", 64'h0000_0000_0001_0000, 1'b0, 2'd0, 2'd0, -1, 0, 1'b0, 64'h1000);

    // R10 request while busy is ignored
    va = 64'h0000_0000_0055_5000;
    build(va, 2'd3, -1, 0, 1'b0, 64'h0000_0000_0123_4000, d);
    set_crs(2'd0, d);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = 1'b0; req_mode = 2'd0; xlate_en = 1'b1;
    @(negedge clk);
    req_vaddr = 64'h0000_0000_0000_0000; xlate_en = 1'b0;
    chk(!ready, "R10", "ready while busy", 64'(ready), 64'd0);
    for (int n = 0; n < 400 && !(done || fault); n++) @(negedge clk);
    req_valid = 1'b0;
    chk(done && paddr == 64'h0000_0000_0123_4000, "R10", "first request result",
        paddr, 64'h0000_0000_0123_4000);
    begin
      int extra = 0;
      for (int n = 0; n < 6; n++) begin
        @(negedge clk);
        if (done || fault) extra++;
      end
      chk(extra == 0 && ready, "R10", "no extra result", 64'(extra), 64'd0);
    end

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [1:0] typ, mode;
      int bl, bk;
      logic [63:0] rp, pv;
      typ  = 2'($urandom);
      mode = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
      pv   = {$urandom, $urandom};
      if ($urandom % 10 != 0) begin
        case (typ)
          2'd2: pv = pv & ((64'd1 << 53) - 1);
          2'd1: pv = pv & ((64'd1 << 42) - 1);
          2'd0: pv = pv & ((64'd1 << 31) - 1);
          default: ;
        endcase
      end
      bl = -1; bk = 0;
      if ($urandom % 4 == 0) begin
        bl = int'($urandom % (int'(typ) + 2));
        bk = (bl == 0) ? 1 : int'(1 + $urandom % 2);
      end
      rp = ($urandom % 8 == 0) ? 64'(($urandom % 3) << 12) : {20'd0, $urandom, 12'd0};
      prefix = {24'd0, 28'($urandom), 12'd0};
      build(pv, typ, bl, bk, ($urandom % 3 == 0), rp, d);
      set_crs(mode, d);
      run_one("R5", pv, 1'($urandom), mode, ($urandom % 10 != 0));
    end

    summary();
  end
endmodule